// File: doc/BRIEF.md
# Microwire EEPROM Boot Loader

This block drives an external serial EEPROM organised as 16-bit words over a four-wire Microwire bus (chip select, serial clock, data toward the memory, data from the memory). When the boot strap input is high at reset release, it fetches words 0 to 6 one after another and fills three host-visible registers: a 48-bit station MAC address, a subsystem vendor ID and a subsystem device ID. A sticky load-done flag tells the rest of the chip when those registers can be trusted. With the strap low, no fetch takes place and the flag rises at once.

Once the boot fetch is over, software can read or write any single word through a command stream (valid/ready) and collect read data on a response stream (valid/ready). A command moves only on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low for the whole boot fetch, for every transfer in flight, and while an earlier response has not been taken. A response holds its data stable until `rsp_ready` is seen high. A write returns no response; it is complete when `cmd_ready` comes back.

The serial clock comes from a divider of the system clock. Every write is preceded automatically by a write-enable command, and is followed by a ready poll on the memory's data output.

Top module: `serial_prom_loader`

## Requirements
- R1: A read frame has three parts. First a start bit of 1, then opcode 10, then the 6-bit word address, MSB first. `mw_di` changes only while `mw_sk` is low. The memory captures each bit on a rising edge of `mw_sk`. The frame is 26 clocks long: the block discards the dummy 0 that follows the address and keeps the next 16 data bits, MSB first.
- R2: With `boot_en` high at reset release, the block reads words 0, 1, 2, 3, 4, 5 and 6 in that order: exactly seven reads, and no word above 6.
- R3: `station_mac[47:40]` is word 1 bits 7:0 and `[39:32]` is word 1 bits 15:8. `[31:24]` and `[23:16]` take word 2 bits 7:0 and 15:8, and `[15:8]` and `[7:0]` take word 3 bits 7:0 and 15:8.
- R4: `sub_vendor_id` is word 5 and `sub_device_id` is word 6. Words 0 and 4 are read but change no register.
- R5: `load_done` rises in the same cycle that the last loaded value appears on the outputs. It then stays high, and the loaded registers no longer change, until the next reset.
- R6: With `boot_en` low at reset release, `load_done` is high by the second clock edge after release. There is no bus activity, and the three registers stay zero.
- R7: `cmd_ready` is low while the boot fetch runs or any transfer is in flight. An accepted command raises `mw_cs` on the next cycle.
- R8: A read command (`cmd_write`=0) produces `rsp_valid` with the word in `rsp_data`. Both hold unchanged while `rsp_ready` is low. No new command is accepted until the response is taken.
- R9: A write command (`cmd_write`=1) first sends write-enable: start 1, opcode 00, address 110000. After that comes the write frame: start 1, opcode 01, the address, and 16 data bits MSB first. The word is then stored in the memory.
- R10: After a write frame, `mw_cs` drops, then rises again with `mw_sk` held low while `mw_do` is sampled. `cmd_ready` returns only after `mw_do` has been seen high.
- R11: One `mw_sk` period is 2*`SK_DIV` system clocks. `mw_cs` stays low for at least one such period between any two bus operations, and `mw_sk` is low whenever `mw_cs` is low.
- R12: During reset `mw_cs`, `mw_sk`, `load_done` and `rsp_valid` are low, and the three registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_en | input | 1 | Strap: enables the automatic word fetch after reset |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_write | input | 1 | 1 = write word, 0 = read word |
| cmd_addr | input | 6 | Word address of the command |
| cmd_wdata | input | 16 | Data for a write command |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 16 | Word returned by a read command |
| mw_cs | output | 1 | Serial memory chip select, active high |
| mw_sk | output | 1 | Serial memory clock |
| mw_di | output | 1 | Serial data toward the memory |
| mw_do | input | 1 | Serial data from the memory; also the ready indication |
| station_mac | output | 48 | Loaded station MAC address |
| sub_vendor_id | output | 16 | Loaded subsystem vendor ID |
| sub_device_id | output | 16 | Loaded subsystem device ID |
| load_done | output | 1 | Boot fetch finished, or skipped by the strap |

## Verification
The assertions assume the command fields stay stable while `cmd_valid` waits for `cmd_ready`. They also assume `boot_en` is settled before reset ends, and that `mw_do` changes no sooner than one system clock after a rising `mw_sk`. The bench drives every input on the falling clock edge and holds command fields until the handshake. Its memory model shifts bits only on observed serial clock rises, keeps the data line low for a fixed busy time after each stored word, and refuses writes that arrive without a prior write-enable. A `SK_DIV` of 2 leaves several system clocks between a data change and the next sample.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 16;
  localparam int HDR_BITS   = 1 + 2 + ADDR_W;
  localparam int FRAME_W    = HDR_BITS + 1 + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_W + 1);
  localparam int LOAD_WORDS = 7;
  localparam int IDX_W      = $clog2(LOAD_WORDS);
  localparam int GAP_TICKS  = 3;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [ADDR_W-1:0] WREN_ADDR = 6'b110000;

  localparam logic [CNT_W-1:0] NB_READ  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] NB_WRITE = CNT_W'(HDR_BITS + DATA_W);
  localparam logic [CNT_W-1:0] NB_WREN  = CNT_W'(HDR_BITS);

  typedef enum logic [2:0] {ST_BOOT, ST_IDLE, ST_XFER, ST_GAP, ST_POLL} seq_state_t;
  typedef enum logic [2:0] {K_NONE, K_READ, K_WREN, K_WRITE, K_POLL} op_kind_t;

  function automatic logic [FRAME_W-1:0] mk_frame(input logic [1:0] opc,
                                                  input logic [ADDR_W-1:0] addr,
                                                  input logic [DATA_W-1:0] data);
    return {1'b1, opc, addr, data, 1'b0};
  endfunction
endpackage

// File: rtl/sprom_clkgen.sv
module sprom_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sprom_shifter.sv
module sprom_shifter
  import sprom_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic [CNT_W-1:0]   nbits,
  input  logic [FRAME_W-1:0] frame,
  input  logic               sd_in,
  output logic               sk,
  output logic               sd_out,
  output logic               done,
  output logic [DATA_W-1:0]  rx
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic               busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
      busy  <= 1'b0;
      sk    <= 1'b0;
      done  <= 1'b0;
      rx    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        shreg <= frame;
        left  <= nbits;
        busy  <= 1'b1;
        sk    <= 1'b0;
      end else if (busy && tick) begin
        if (!sk) begin
          sk <= 1'b1;
          rx <= {rx[DATA_W-2:0], sd_in};
        end else begin
          sk    <= 1'b0;
          shreg <= shreg << 1;
          left  <= left - 1'b1;
          if (left == CNT_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  assign sd_out = busy & shreg[FRAME_W-1];
endmodule

// File: rtl/sprom_bootregs.sv
module sprom_bootregs
  import sprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] word,
  output logic [47:0]       mac,
  output logic [DATA_W-1:0] vid,
  output logic [DATA_W-1:0] did
);
  localparam int MAC_WORDS = 3;
  localparam int MAC_BASE  = 1;
  localparam int VID_IDX   = 5;
  localparam int DID_IDX   = 6;

  for (genvar g = 0; g < MAC_WORDS; g++) begin : g_mac
    logic [15:0] pair;
    always_ff @(posedge clk) begin
      if (!rst_n) pair <= '0;
      else if (we && idx == IDX_W'(MAC_BASE + g)) pair <= {word[7:0], word[15:8]};
    end
    assign mac[47-16*g -: 16] = pair;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid <= '0;
      did <= '0;
    end else if (we) begin
      if (idx == IDX_W'(VID_IDX)) vid <= word;
      if (idx == IDX_W'(DID_IDX)) did <= word;
    end
  end
endmodule

// File: rtl/sprom_seq.sv
module sprom_seq
  import sprom_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_en,
  input  logic               tick,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_write,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               eng_start,
  output logic [CNT_W-1:0]   eng_nbits,
  output logic [FRAME_W-1:0] eng_frame,
  input  logic               eng_done,
  input  logic [DATA_W-1:0]  eng_rx,
  input  logic               sd_in,
  output logic               cs,
  output logic               load_done,
  output logic               boot_we,
  output logic [IDX_W-1:0]   boot_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LOAD_WORDS - 1);
  localparam int GW = $clog2(GAP_TICKS + 1);

  seq_state_t        state;
  op_kind_t          kind;
  logic              loading;
  logic [GW-1:0]     gap_cnt;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  assign cmd_ready = (state == ST_IDLE) && load_done && !rsp_valid;
  assign cs        = (state == ST_XFER) || (state == ST_POLL);
  assign boot_we   = (state == ST_XFER) && eng_done && (kind == K_READ) && loading;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_BOOT;
      kind      <= K_NONE;
      loading   <= 1'b0;
      load_done <= 1'b0;
      gap_cnt   <= '0;
      boot_idx  <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      eng_start <= 1'b0;
      eng_nbits <= '0;
      eng_frame <= '0;
    end else begin
      eng_start <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state)
        ST_BOOT: begin
          if (boot_en) begin
            loading  <= 1'b1;
            boot_idx <= '0;
            gap_cnt  <= '0;
            state    <= ST_GAP;
          end else begin
            load_done <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (loading) begin
            eng_frame <= mk_frame(OPC_READ, ADDR_W'(boot_idx), '0);
            eng_nbits <= NB_READ;
            eng_start <= 1'b1;
            kind      <= K_READ;
            state     <= ST_XFER;
          end else if (cmd_valid && cmd_ready) begin
            eng_start <= 1'b1;
            state     <= ST_XFER;
            if (cmd_write) begin
              wr_addr   <= cmd_addr;
              wr_data   <= cmd_wdata;
              eng_frame <= mk_frame(OPC_EXT, WREN_ADDR, '0);
              eng_nbits <= NB_WREN;
              kind      <= K_WREN;
            end else begin
              eng_frame <= mk_frame(OPC_READ, cmd_addr, '0);
              eng_nbits <= NB_READ;
              kind      <= K_READ;
            end
          end
        end
        ST_XFER: begin
          if (eng_done) begin
            state   <= ST_GAP;
            gap_cnt <= '0;
            case (kind)
              K_READ: begin
                kind <= K_NONE;
                if (loading) begin
                  if (boot_idx == LAST_IDX) begin
                    loading   <= 1'b0;
                    load_done <= 1'b1;
                  end else begin
                    boot_idx <= boot_idx + 1'b1;
                  end
                end else begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= eng_rx;
                end
              end
              K_WREN:  kind <= K_WRITE;
              K_WRITE: kind <= K_POLL;
              default: kind <= K_NONE;
            endcase
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_cnt == GW'(GAP_TICKS - 1)) begin
              case (kind)
                K_WRITE: begin
                  eng_frame <= mk_frame(OPC_WRITE, wr_addr, wr_data);
                  eng_nbits <= NB_WRITE;
                  eng_start <= 1'b1;
                  state     <= ST_XFER;
                end
                K_POLL:  state <= ST_POLL;
                default: state <= ST_IDLE;
              endcase
            end else begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          end
        end
        ST_POLL: begin
          if (tick && sd_in) begin
            kind    <= K_NONE;
            gap_cnt <= '0;
            state   <= ST_GAP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_prom_loader.sv
module serial_prom_loader
  import sprom_pkg::*;
#(
  parameter int SK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_en,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_write,
  input  logic [5:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_data,
  output logic        mw_cs,
  output logic        mw_sk,
  output logic        mw_di,
  input  logic        mw_do,
  output logic [47:0] station_mac,
  output logic [15:0] sub_vendor_id,
  output logic [15:0] sub_device_id,
  output logic        load_done
);
  logic               tick;
  logic               eng_start;
  logic [CNT_W-1:0]   eng_nbits;
  logic [FRAME_W-1:0] eng_frame;
  logic               eng_done;
  logic [DATA_W-1:0]  eng_rx;
  logic               boot_we;
  logic [IDX_W-1:0]   boot_idx;

  sprom_clkgen #(.DIV(SK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sprom_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(eng_start),
    .nbits(eng_nbits), .frame(eng_frame), .sd_in(mw_do),
    .sk(mw_sk), .sd_out(mw_di), .done(eng_done), .rx(eng_rx)
  );

  sprom_seq u_seq (
    .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .eng_start(eng_start), .eng_nbits(eng_nbits), .eng_frame(eng_frame),
    .eng_done(eng_done), .eng_rx(eng_rx), .sd_in(mw_do), .cs(mw_cs),
    .load_done(load_done), .boot_we(boot_we), .boot_idx(boot_idx)
  );

  sprom_bootregs u_regs (
    .clk(clk), .rst_n(rst_n), .we(boot_we), .idx(boot_idx), .word(eng_rx),
    .mac(station_mac), .vid(sub_vendor_id), .did(sub_device_id)
  );
endmodule

// File: rtl/serial_prom_loader_chk.sv
module serial_prom_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic        mw_cs,
  input logic        mw_sk,
  input logic [47:0] station_mac,
  input logic [15:0] sub_vendor_id,
  input logic [15:0] sub_device_id,
  input logic        load_done
);
  assert_sk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mw_cs |-> !mw_sk);

  assert_no_cmd_in_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> load_done);

  assert_accept_selects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> mw_cs);

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);

  assert_regs_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> ($stable(station_mac) && $stable(sub_vendor_id) && $stable(sub_device_id)));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_busy_while_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
endmodule

bind serial_prom_loader serial_prom_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .mw_cs(mw_cs), .mw_sk(mw_sk), .station_mac(station_mac),
  .sub_vendor_id(sub_vendor_id), .sub_device_id(sub_device_id),
  .load_done(load_done)
);

// File: tb/tb_serial_prom_loader.sv
module tb_serial_prom_loader;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int BUSY = 40;
  localparam int NVEC = 8;

  function automatic logic [15:0] mem_init(input logic [5:0] a);
    return {4'hC, a, ~a};
  endfunction

  // {write, addr, wdata, expected read}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b1, 6'd10, 16'hBEEF, 16'h0000},
    {1'b0, 6'd10, 16'h0000, 16'hBEEF},
    {1'b0, 6'd20, 16'h0000, mem_init(6'd20)},
    {1'b1, 6'd63, 16'h0001, 16'h0000},
    {1'b0, 6'd63, 16'h0000, 16'h0001},
    {1'b1, 6'd0,  16'hFFFF, 16'h0000},
    {1'b0, 6'd0,  16'h0000, 16'hFFFF},
    {1'b0, 6'd7,  16'h0000, mem_init(6'd7)}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, boot_en, cmd_valid, cmd_ready, cmd_write, rsp_valid, rsp_ready;
  logic [5:0] cmd_addr;
  logic [15:0] cmd_wdata, rsp_data, sub_vendor_id, sub_device_id;
  logic mw_cs, mw_sk, mw_di, mw_do, load_done;
  logic [47:0] station_mac;

  serial_prom_loader #(.SK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .boot_en(boot_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do),
    .station_mac(station_mac), .sub_vendor_id(sub_vendor_id),
    .sub_device_id(sub_device_id), .load_done(load_done)
  );

  // ---------------- serial memory model ----------------
  logic [15:0] prom [64];
  logic mdl_init = 1'b0;
  logic sk_q = 1'b0, cs_q = 1'b0;
  int nrise = 0;
  logic [24:0] hdr = '0;
  logic rd_mode = 1'b0, rd_bit = 1'b0, wen = 1'b0, wr_pend = 1'b0;
  logic [15:0] rd_word = '0, wr_data = '0;
  logic [3:0] rd_pos = '0;
  logic [5:0] wr_addr = '0;
  int busy_cnt = 0, n_reads = 0, n_wren = 0, n_writes = 0, max_rd = 0;
  int low_cnt = 0, min_gap = 100000;
  logic seen_cs = 1'b0;

  assign mw_do = rd_mode ? rd_bit : (busy_cnt == 0);

  always @(posedge clk) begin
    logic [24:0] shin;
    if (!mdl_init) begin
      for (int i = 0; i < 64; i++) prom[i] <= mem_init(6'(i));
      mdl_init <= 1'b1;
    end
    sk_q <= mw_sk;
    cs_q <= mw_cs;
    low_cnt <= mw_cs ? 0 : low_cnt + 1;
    if (mw_cs && !cs_q) begin
      nrise <= 0;
      hdr <= '0;
      rd_mode <= 1'b0;
      if (seen_cs && low_cnt < min_gap) min_gap <= low_cnt;
      seen_cs <= 1'b1;
    end
    if (!mw_cs && cs_q) begin
      rd_mode <= 1'b0;
      if (wr_pend) begin
        prom[wr_addr] <= wr_data;
        busy_cnt <= BUSY;
        wr_pend <= 1'b0;
        n_writes <= n_writes + 1;
      end
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
    end
    if (mw_cs && cs_q && mw_sk && !sk_q) begin
      shin = {hdr[23:0], mw_di};
      hdr <= shin;
      nrise <= nrise + 1;
      if (nrise == 8 && shin[8]) begin
        if (shin[7:6] == 2'b10) begin
          rd_mode <= 1'b1;
          rd_bit  <= 1'b0;
          rd_word <= prom[shin[5:0]];
          rd_pos  <= 4'd15;
          n_reads <= n_reads + 1;
          if (int'(shin[5:0]) > max_rd) max_rd <= int'(shin[5:0]);
        end else if (shin[7:6] == 2'b00 && shin[5:4] == 2'b11) begin
          wen <= 1'b1;
          n_wren <= n_wren + 1;
        end
      end
      if (rd_mode && nrise >= 9) begin
        rd_bit <= rd_word[rd_pos];
        rd_pos <= rd_pos - 1'b1;
      end
      if (nrise == 24 && shin[24] && shin[23:22] == 2'b01 && wen) begin
        wr_pend <= 1'b1;
        wr_addr <= shin[21:16];
        wr_data <= shin[15:0];
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [5:0] a, output logic [15:0] d);
    cmd_write = 1'b0; cmd_addr = a; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d);
    cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    chk("R10 memory ready before cmd_ready", 48'(busy_cnt), 48'd0);
    chk("R9 word stored", 48'(prom[a]), 48'(d));
  endtask

  logic [47:0] exp_mac;
  logic [15:0] rd, held;
  int reads_snap, writes_in_table;

  initial begin
    rst_n = 1'b0; boot_en = 1'b1; cmd_valid = 1'b0; cmd_write = 1'b0;
    cmd_addr = '0; cmd_wdata = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 reset cs/sk", {46'd0, mw_cs, mw_sk}, 48'd0);
    chk("R12 reset load_done/rsp_valid", {46'd0, load_done, rsp_valid}, 48'd0);
    chk("R12 reset mac", station_mac, 48'd0);
    rst_n = 1'b1;

    repeat (60) @(negedge clk);
    chk("R7 cmd_ready low during load", {46'd0, cmd_ready, load_done}, 48'd0);
    while (!load_done) @(negedge clk);
    exp_mac = {mem_init(6'd1)[7:0], mem_init(6'd1)[15:8],
               mem_init(6'd2)[7:0], mem_init(6'd2)[15:8],
               mem_init(6'd3)[7:0], mem_init(6'd3)[15:8]};
    chk("R3 station mac", station_mac, exp_mac);
    chk("R4 vendor id word 5", 48'(sub_vendor_id), 48'(mem_init(6'd5)));
    chk("R4 device id word 6", 48'(sub_device_id), 48'(mem_init(6'd6)));
    chk("R2 boot read count", 48'(n_reads), 48'd7);
    chk("R2 highest word read", 48'(max_rd), 48'd6);

    writes_in_table = 0;
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][38]) begin
        do_write(VEC[i][37:32], VEC[i][31:16]);
        writes_in_table++;
      end else begin
        do_read(VEC[i][37:32], rd);
        chk("R1 R8 read data", 48'(rd), 48'(VEC[i][15:0]));
      end
    end
    chk("R9 write-enable before each write", 48'(n_wren), 48'(writes_in_table));
    chk("R9 writes stored", 48'(n_writes), 48'(writes_in_table));
    chk("R11 min cs low gap", 48'(min_gap >= 2*DIV), 48'd1);

    // back-pressure on the response stream
    rsp_ready = 1'b0;
    cmd_write = 1'b0; cmd_addr = 6'd10; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    repeat (20) @(negedge clk);
    chk("R8 rsp held under back-pressure", {31'd0, rsp_valid, rsp_data}, {31'd0, 1'b1, held});
    chk("R8 no accept while rsp pending", 48'(cmd_ready), 48'd0);
    chk("R8 held data value", 48'(held), 48'hBEEF);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R8 rsp taken", 48'(rsp_valid), 48'd0);

    // strap low
    rst_n = 1'b0; boot_en = 1'b0;
    repeat (3) @(negedge clk);
    reads_snap = n_reads;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 load_done immediate", 48'(load_done), 48'd1);
    repeat (100) @(negedge clk);
    chk("R6 no bus activity", 48'(n_reads), 48'(reads_snap));
    chk("R6 registers zero", station_mac | 48'(sub_vendor_id) | 48'(sub_device_id), 48'd0);
    do_read(6'd63, rd);
    chk("R1 R7 command after skipped load", 48'(rd), 48'h0001);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule